// File: doc/BRIEF.md
# ADC Offset Cancellation Loop

This block estimates the DC offset present in a stream of signed converter samples. It produces a correction code for a DAC. An analog subtractor in front of the converter takes that code away from the input. The converter therefore delivers the residual error, and the block integrates that residual in a first-order loop. Each accepted sample is scaled down by a power-of-two gain and added to a fixed-point accumulator. The accumulator keeps fractional bits below one DAC step, and its integer part is the DAC code.

A calibration pass begins straight out of reset, and it begins again whenever the calibrate command is pulsed. During this pass the converter input is taken to be grounded, so every sample is pure offset. The pass ends when the residual has read exactly zero (below one LSB) for a run of consecutive samples. The block then raises its done and converged flags. After calibration a mode input chooses between two behaviours. In one, the loop keeps tracking. In the other, the calibrated code is frozen.

Top module: `dc_offset_loop`

## Requirements
- R1: While reset is asserted and in the first cycle after it, dacCode is 0 and calDone and converged are 0. A calibration pass is active from reset onward.
- R2: The accumulator has DAC_W integer bits and FRAC_W fraction bits, and it is updated only in a cycle where adcValid is 1 and either calibration is active or trackMode is 1. On such an update it adds (adcSample * 2^FRAC_W) arithmetically shifted right by gainShift. dacCode is the floor of the accumulator divided by 2^FRAC_W, and it shows the result in the cycle after the sample.
- R3: A gainShift value of 0 is treated as 1. Every other value from 1 to 15 is used as given.
- R4: The accumulator saturates at the largest and smallest values its width can hold and never wraps. With the defaults, dacCode therefore stops at +511 and at -512.
- R5: During calibration, when adcValid is high for the 16th consecutive sample equal to zero, calibration ends and calDone and converged go to 1 in the next cycle. A valid nonzero sample restarts the run. Cycles without adcValid leave the run unchanged.
- R6: After calibration with trackMode = 0, dacCode is frozen whatever the samples are.
- R7: After calibration with trackMode = 1, the loop keeps updating as in R2, and calDone and converged stay at 1.
- R8: calStart clears calDone and converged, clears the zero run and starts a calibration pass. When it falls in the same cycle as the 16th zero sample, the clear wins and the flags stay 0.
- R9: In a cycle where adcValid is 0, dacCode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| adcSample | input | ADC_W | Signed residual sample from the converter |
| adcValid | input | 1 | adcSample is valid this cycle |
| calStart | input | 1 | Pulse that starts a calibration pass |
| trackMode | input | 1 | 1 = keep tracking after calibration, 0 = freeze the code |
| gainShift | input | 4 | Loop gain as a right shift; 0 acts as 1 |
| dacCode | output | DAC_W | Signed correction code sent to the DAC |
| calDone | output | 1 | The last calibration pass completed |
| converged | output | 1 | The residual stayed below one LSB for the full run |

## Verification
Two events can fall on the same edge: the 16th zero sample that would finish calibration, and a fresh calStart. The bench feeds exactly fifteen zero samples and then pulses calStart together with the sixteenth. Both flags must stay low, and a complete new run of sixteen is then needed before they rise. A second coincidence is a calStart on a valid sample. The sample must still be integrated under the mode that held before that edge, and the bench model checks this on every step.

// File: rtl/dc_offset_pkg.sv
package dc_offset_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accEn;
  } loopCtrl_t;
endpackage

// File: rtl/dc_offset_datapath.sv
module dc_offset_datapath
  import dc_offset_pkg::*;
#(
  parameter int ADC_W  = 12,
  parameter int DAC_W  = 10,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  loopCtrl_t               ctrl,
  input  logic signed [ADC_W-1:0] adcSample,
  input  logic [3:0]              gainShift,
  output logic                    sampleQuiet,
  output logic signed [DAC_W-1:0] dacCode
);
  localparam int ACC_W  = DAC_W + FRAC_W;
  localparam int SCL_W  = ADC_W + FRAC_W;
  localparam int SUM_W  = ((SCL_W > ACC_W) ? SCL_W : ACC_W) + 2;
  localparam logic signed [SUM_W-1:0] ACC_ONE = SUM_W'(1) <<< (ACC_W - 1);
  localparam logic signed [SUM_W-1:0] ACC_MAX = ACC_ONE - 1;
  localparam logic signed [SUM_W-1:0] ACC_MIN = -ACC_ONE;

  logic signed [ACC_W-1:0] accQ;
  logic signed [SUM_W-1:0] sampleExt, scaled, accExt, sumRaw;
  logic signed [ACC_W-1:0] sumSat;
  logic [3:0]              shiftEff;

  assign shiftEff  = (gainShift == 4'd0) ? 4'd1 : gainShift;
  assign sampleExt = {{(SUM_W-ADC_W){adcSample[ADC_W-1]}}, adcSample};
  assign scaled    = (sampleExt <<< FRAC_W) >>> shiftEff;
  assign accExt    = {{(SUM_W-ACC_W){accQ[ACC_W-1]}}, accQ};
  assign sumRaw    = accExt + scaled;

  always_comb begin
    if (sumRaw > ACC_MAX)      sumSat = ACC_MAX[ACC_W-1:0];
    else if (sumRaw < ACC_MIN) sumSat = ACC_MIN[ACC_W-1:0];
    else                       sumSat = sumRaw[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           accQ <= '0;
    else if (ctrl.accEn) accQ <= sumSat;
  end

  assign sampleQuiet = (adcSample == '0);
  assign dacCode     = accQ[ACC_W-1:FRAC_W];
endmodule

// File: rtl/dc_offset_ctrl.sv
module dc_offset_ctrl
  import dc_offset_pkg::*;
#(
  parameter int QUIET_RUN = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      adcValid,
  input  logic      sampleQuiet,
  input  logic      calStart,
  input  logic      trackMode,
  output loopCtrl_t ctrl,
  output logic      calDone,
  output logic      converged
);
  localparam int CNT_W = $clog2(QUIET_RUN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUIET_RUN - 1);

  logic             calActive;
  logic [CNT_W-1:0] quietCnt;

  assign ctrl.accEn = adcValid && (calActive || trackMode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      calActive <= 1'b1;
      quietCnt  <= '0;
      calDone   <= 1'b0;
      converged <= 1'b0;
    end else if (calStart) begin
      calActive <= 1'b1;
      quietCnt  <= '0;
      calDone   <= 1'b0;
      converged <= 1'b0;
    end else if (calActive && adcValid) begin
      if (!sampleQuiet) begin
        quietCnt <= '0;
      end else if (quietCnt == LAST) begin
        calActive <= 1'b0;
        quietCnt  <= '0;
        calDone   <= 1'b1;
        converged <= 1'b1;
      end else begin
        quietCnt <= quietCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dc_offset_loop.sv
module dc_offset_loop
  import dc_offset_pkg::*;
#(
  parameter int ADC_W     = 12,
  parameter int DAC_W     = 10,
  parameter int FRAC_W    = 8,
  parameter int QUIET_RUN = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [ADC_W-1:0] adcSample,
  input  logic                    adcValid,
  input  logic                    calStart,
  input  logic                    trackMode,
  input  logic [3:0]              gainShift,
  output logic signed [DAC_W-1:0] dacCode,
  output logic                    calDone,
  output logic                    converged
);
  loopCtrl_t ctrl;
  logic      sampleQuiet;

  dc_offset_ctrl #(.QUIET_RUN(QUIET_RUN)) uCtrl (
    .clk(clk), .rstN(rstN), .adcValid(adcValid), .sampleQuiet(sampleQuiet),
    .calStart(calStart), .trackMode(trackMode), .ctrl(ctrl),
    .calDone(calDone), .converged(converged)
  );

  dc_offset_datapath #(.ADC_W(ADC_W), .DAC_W(DAC_W), .FRAC_W(FRAC_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .adcSample(adcSample),
    .gainShift(gainShift), .sampleQuiet(sampleQuiet), .dacCode(dacCode)
  );
endmodule

// File: rtl/dc_offset_loop_checker.sv
module dc_offset_loop_checker #(
  parameter int ADC_W = 12,
  parameter int DAC_W = 10
) (
  input logic                    clk,
  input logic                    rstN,
  input logic signed [ADC_W-1:0] adcSample,
  input logic                    adcValid,
  input logic                    calStart,
  input logic                    trackMode,
  input logic signed [DAC_W-1:0] dacCode,
  input logic                    calDone,
  input logic                    converged
);
  localparam logic signed [DAC_W-1:0] CODE_TOP = {1'b0, {(DAC_W-1){1'b1}}};
  localparam logic signed [DAC_W-1:0] CODE_BOT = {1'b1, {(DAC_W-1){1'b0}}};

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !adcValid |=> $stable(dacCode));

  assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && !trackMode && !calStart) |=> $stable(dacCode));

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> (!calDone && !converged));

  assert_done_on_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> ($past(adcValid) && $past(adcSample) == '0 && converged));

  assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dacCode == CODE_TOP && adcValid && adcSample > 0) |=> dacCode == CODE_TOP);

  assert_no_wrap_bot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dacCode == CODE_BOT && adcValid && adcSample < 0) |=> dacCode == CODE_BOT);
endmodule

bind dc_offset_loop dc_offset_loop_checker #(.ADC_W(ADC_W), .DAC_W(DAC_W)) uChk (
  .clk(clk), .rstN(rstN), .adcSample(adcSample), .adcValid(adcValid),
  .calStart(calStart), .trackMode(trackMode), .dacCode(dacCode),
  .calDone(calDone), .converged(converged)
);

// File: tb/dc_offset_loop_test.sv
module dc_offset_loop_test;
  localparam int ADC_W = 12, DAC_W = 10, FRAC_W = 8, RUN = 16;
  localparam longint ACC_MAX = (64'sd1 <<< (DAC_W + FRAC_W - 1)) - 1;
  localparam longint ACC_MIN = -(64'sd1 <<< (DAC_W + FRAC_W - 1));

  logic clk = 0, rstN = 0;
  logic signed [ADC_W-1:0] adcSample = '0;
  logic adcValid = 0, calStart = 0, trackMode = 0;
  logic [3:0] gainShift = 4'd2;
  logic signed [DAC_W-1:0] dacCode;
  logic calDone, converged;

  int checks = 0, fails = 0;
  longint accM = 0;
  bit calM = 1, doneM = 0;
  int cntM = 0;

  always #2.5 clk = ~clk;

  dc_offset_loop uut (
    .clk(clk), .rstN(rstN), .adcSample(adcSample), .adcValid(adcValid),
    .calStart(calStart), .trackMode(trackMode), .gainShift(gainShift),
    .dacCode(dacCode), .calDone(calDone), .converged(converged)
  );

  function automatic longint expDac(longint a);
    return a >>> FRAC_W;
  endfunction

  function automatic longint nextAcc(longint a, longint s, int k);
    longint r;
    int kk = (k == 0) ? 1 : k;
    r = a + ((s <<< FRAC_W) >>> kk);
    if (r > ACC_MAX) r = ACC_MAX;
    if (r < ACC_MIN) r = ACC_MIN;
    return r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, update the model, compare after the edge
  task automatic step(bit v, longint s, bit cs, string req);
    @(negedge clk);
    adcValid = v; adcSample = s[ADC_W-1:0]; calStart = cs;
    @(posedge clk);
    #1;
    if (v && (calM || trackMode)) accM = nextAcc(accM, s, int'(gainShift));
    if (cs) begin calM = 1; cntM = 0; doneM = 0; end
    else if (calM && v) begin
      if (s != 0) cntM = 0;
      else if (cntM == RUN - 1) begin calM = 0; cntM = 0; doneM = 1; end
      else cntM++;
    end
    check({req, " dacCode"}, longint'(dacCode), expDac(accM));
    check({req, " calDone"}, longint'(calDone), longint'(doneM));
    check({req, " converged"}, longint'(converged), longint'(doneM));
    adcValid = 0; calStart = 0;
  endtask

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    longint offs;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset dacCode", longint'(dacCode), 0);
    check("R1 reset calDone", longint'(calDone), 0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    check("R1 first cycle dacCode", longint'(dacCode), 0);
    check("R1 first cycle converged", longint'(converged), 0);

    // R2/R5: power-up calibration against an emulated offset
    offs = 37; gainShift = 4'd2;
    for (int i = 0; i < 400 && !doneM; i++)
      step(1, offs - longint'(dacCode), 0, "R2 R5 cal");
    check("R5 calibration finished", longint'(calDone), 1);
    check("R5 code equals offset", longint'(dacCode), offs);

    // R6: hold mode freezes code
    trackMode = 0;
    for (int i = 0; i < 20; i++)
      step(1, $signed(12'($urandom)), 0, "R6 hold");
    check("R6 code frozen", longint'(dacCode), offs);

    // R8: restart coincident with final zero sample
    step(0, 0, 1, "R8 start");
    for (int i = 0; i < RUN - 1; i++) step(1, 0, 0, "R8 zeros");
    step(0, 0, 0, "R9 gap keeps run");
    step(1, 0, 1, "R8 collide");
    check("R8 clear wins", longint'(calDone), 0);
    for (int i = 0; i < RUN - 1; i++) step(1, 0, 0, "R8 rerun");
    check("R5 not yet at 15", longint'(calDone), 0);
    step(1, 0, 0, "R5 16th zero");
    check("R5 done after 16", longint'(converged), 1);

    // R5: nonzero breaks the run
    step(1, 0, 1, "R8 restart");
    for (int i = 0; i < 10; i++) step(1, 0, 0, "R5 run");
    step(1, 1, 0, "R5 break");
    for (int i = 0; i < RUN - 1; i++) step(1, 0, 0, "R5 after break");
    check("R5 run restarted", longint'(calDone), 0);
    step(1, 0, 0, "R5 complete");

    // R7 R9: tracking with random samples, shifts and valids
    trackMode = 1;
    for (int i = 0; i < 300; i++) begin
      gainShift = 4'($urandom);
      step(($urandom % 4) != 0, longint'($signed(12'($urandom_range(0, 4095)))) >>> ($urandom % 6),
           0, "R2 R7 R9 track");
    end

    // R3: shift of zero acts as one
    gainShift = 4'd0;
    step(1, 100, 0, "R3 shift0");
    gainShift = 4'd1;
    step(1, -100, 0, "R3 shift1");

    // R4: saturation both ways
    for (int i = 0; i < 200; i++) step(1, 2047, 0, "R4 top");
    check("R4 top code", longint'(dacCode), 511);
    for (int i = 0; i < 400; i++) step(1, -2048, 0, "R4 bottom");
    check("R4 bottom code", longint'(dacCode), -512);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule